// File: doc/BRIEF.md
# Synthesizer Counter Word Loader

This block holds the divider settings of an integer-N frequency synthesizer. It supplies a 9-bit main divide value, a 6-bit reference divide value, a 4-bit swallow value, a prescaler-enable bit and an 8-bit enhancement control byte. Settings reach it in one of three ways. A three-wire serial stream, parallel byte writes and static pins directly are each chosen by two mode pins.

The counter settings are double-buffered. Serial bits or parallel bytes build a staging word, and a separate transfer strobe copies that word to the active outputs. A second serial destination, the enhancement register, shares the serial shift path. The level of an enhancement-select pin steers the bits to it, and the falling edge of that pin commits them. All strobes and mode pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the block acts on their detected edges three clock rises after a pin change. A sticky-until-next-commit flag reports a serial commit whose bit count did not match the register width.

Top module: `synth_word_loader`

## Requirements
- R1: After reset, mVal, rVal, aVal, preEn, enhCtl and lenErr are all zero.
- R2: With directSelIn high the block is in direct mode whatever serialSelIn is. With directSelIn low, serialSelIn high selects serial mode and serialSelIn low selects parallel mode.
- R3: In serial mode each rising edge of sclkIn while enhWrIn is low shifts sdataIn into the 20-bit staging word, first bit ending at the top. The word layout is M in bits 19:11, R in bits 10:5, A in bits 4:1 and the prescaler enable in bit 0.
- R4: A rising edge of primWrIn in serial or parallel mode copies the staging word to the active counter outputs. The outputs do not change at any other time outside direct mode.
- R5: In serial mode, rising sclkIn edges while enhWrIn is high shift sdataIn into an 8-bit enhancement shift register, most significant first. A falling edge of enhWrIn in serial mode commits it to the enhancement buffer. A falling edge in another mode does nothing.
- R6: enhCtl equals the enhancement buffer while enhEnN is low and is zero while enhEnN is high.
- R7: In parallel mode a rising edge of mLoWrIn writes parBus to M[7:0]. A rising edge of mHiWrIn writes parBus[7] to the prescaler enable, parBus[6] to M[8] and parBus[5:0] to R. A rising edge of aWrIn writes parBus[3:0] to A. Each write goes to the staging word.
- R8: In direct mode the outputs follow pinM, pinR, pinA and pinPre, with M[8:7] and R[5:4] driven zero. Transfer strobes are ignored, so the active word is unchanged on leaving direct mode.
- R9: sclkIn edges have no effect outside serial mode. Parallel byte strobes have no effect outside parallel mode.
- R10: A serial-mode transfer sets lenErr to 1 when the number of bits shifted into the staging word since the previous transfer differs from 20, and to 0 otherwise. A parallel-mode transfer clears it. An enhancement commit sets it when its bit count differs from 8.
- R11: A word longer than the register keeps only its most recent bits. The oldest bits are shifted out and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdataIn | input | 1 | Serial data |
| sclkIn | input | 1 | Serial shift clock (asynchronous) |
| primWrIn | input | 1 | Staging-to-active transfer strobe |
| enhWrIn | input | 1 | Enhancement select level and commit strobe |
| enhEnN | input | 1 | Active-low enhancement output enable |
| directSelIn | input | 1 | Direct mode select |
| serialSelIn | input | 1 | Serial (1) or parallel (0) select |
| parBus | input | 8 | Parallel byte data |
| mLoWrIn | input | 1 | Parallel strobe for M[7:0] |
| mHiWrIn | input | 1 | Parallel strobe for prescaler, M[8], R |
| aWrIn | input | 1 | Parallel strobe for A |
| pinM | input | 7 | Direct-mode M[6:0] |
| pinR | input | 4 | Direct-mode R[3:0] |
| pinA | input | 4 | Direct-mode A |
| pinPre | input | 1 | Direct-mode prescaler enable |
| mVal | output | 9 | Main divide value |
| rVal | output | 6 | Reference divide value |
| aVal | output | 4 | Swallow value |
| preEn | output | 1 | Prescaler enable |
| enhCtl | output | 8 | Gated enhancement control byte |
| lenErr | output | 1 | Bit-count mismatch at last commit |

## Verification
Serial words of exactly 20 bits confirm the field layout. Short words of 17 bits and long words of 23 bits separate a correct mismatch flag from a stuck one, and the long words show which bits survive an overflow. Partial shifts followed by a check before the transfer reveal any leak of staging data to the outputs. Strobes issued in the wrong mode (clocks in parallel mode, byte strobes in serial mode, transfers in direct mode, enhancement falls outside serial mode) show that mode gating is applied per path. Random mixes of all modes, with random fields and gate toggles, then compare every output against a bench model after each operation.

// File: rtl/synth_ld_pkg.sv
package synth_ld_pkg;
  localparam int M_W    = 9;
  localparam int R_W    = 6;
  localparam int A_W    = 4;
  localparam int ENH_W  = 8;
  localparam int PAR_W  = 8;
  localparam int M_KEEP = 7;
  localparam int R_KEEP = 4;
  localparam int PRIM_W = M_W + R_W + A_W + 1;
  localparam int PRE_POS = 0;
  localparam int A_LSB  = PRE_POS + 1;
  localparam int R_LSB  = A_LSB + A_W;
  localparam int M_LSB  = R_LSB + R_W;
  localparam int CNT_W  = $clog2(PRIM_W + 2);

  typedef struct packed {
    logic shiftPrim;
    logic shiftEnh;
    logic sdataBit;
    logic ldMLo;
    logic ldMHi;
    logic ldA;
    logic commitPrim;
    logic captureEnh;
    logic serialMode;
    logic directMode;
  } ldStrobe_t;
endpackage

// File: rtl/synth_ld_sync.sv
module synth_ld_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/synth_ld_ctrl.sv
module synth_ld_ctrl
  import synth_ld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdataIn,
  input  logic       sclkIn,
  input  logic       primWrIn,
  input  logic       enhWrIn,
  input  logic       mLoWrIn,
  input  logic       mHiWrIn,
  input  logic       aWrIn,
  input  logic       directSelIn,
  input  logic       serialSelIn,
  output ldStrobe_t  strb
);
  localparam int NSYNC   = 8;
  localparam int I_SCLK  = 0;
  localparam int I_PWR   = 1;
  localparam int I_EWR   = 2;
  localparam int I_MLO   = 3;
  localparam int I_MHI   = 4;
  localparam int I_AWR   = 5;
  localparam int I_DIR   = 6;
  localparam int I_SER   = 7;

  logic [NSYNC-1:0] rawPins, syncd, prevQ, riseQ, fallQ;
  logic serialMode, parMode, directMode;

  assign rawPins = {serialSelIn, directSelIn, aWrIn, mHiWrIn, mLoWrIn,
                    enhWrIn, primWrIn, sclkIn};

  synth_ld_sync #(.W(NSYNC)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (rawPins),
    .q    (syncd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncd;
  end

  assign riseQ = syncd & ~prevQ;
  assign fallQ = ~syncd & prevQ;

  assign directMode = syncd[I_DIR];
  assign serialMode = !syncd[I_DIR] && syncd[I_SER];
  assign parMode    = !syncd[I_DIR] && !syncd[I_SER];

  always_comb begin
    strb            = '0;
    strb.sdataBit   = sdataIn;
    strb.serialMode = serialMode;
    strb.directMode = directMode;
    strb.shiftPrim  = serialMode && riseQ[I_SCLK] && !syncd[I_EWR];
    strb.shiftEnh   = serialMode && riseQ[I_SCLK] && syncd[I_EWR];
    strb.ldMLo      = parMode && riseQ[I_MLO];
    strb.ldMHi      = parMode && riseQ[I_MHI];
    strb.ldA        = parMode && riseQ[I_AWR];
    strb.commitPrim = !directMode && riseQ[I_PWR];
    strb.captureEnh = serialMode && fallQ[I_EWR];
  end

  // R2: serial shifting and parallel loads never occur in the same cycle
  p_excl_paths_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftPrim | strb.shiftEnh, strb.ldMLo | strb.ldMHi | strb.ldA}));
endmodule

// File: rtl/synth_ld_dpath.sv
module synth_ld_dpath
  import synth_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strb,
  input  logic [PAR_W-1:0]  parBus,
  input  logic              enhEnN,
  input  logic [M_KEEP-1:0] pinM,
  input  logic [R_KEEP-1:0] pinR,
  input  logic [A_W-1:0]    pinA,
  input  logic              pinPre,
  output logic [M_W-1:0]    mVal,
  output logic [R_W-1:0]    rVal,
  output logic [A_W-1:0]    aVal,
  output logic              preEn,
  output logic [ENH_W-1:0]  enhCtl,
  output logic              lenErr
);
  localparam logic [CNT_W-1:0] PRIM_CNT = CNT_W'(PRIM_W);
  localparam logic [CNT_W-1:0] ENH_CNT  = CNT_W'(ENH_W);

  logic [PRIM_W-1:0] stageWord, actWord;
  logic [ENH_W-1:0]  enhShift, enhBuf;
  logic [CNT_W-1:0]  primCnt, enhCnt;

  // staging word: serial shift or parallel byte writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageWord <= '0;
      primCnt   <= '0;
    end else begin
      if (strb.shiftPrim) begin
        stageWord <= {stageWord[PRIM_W-2:0], strb.sdataBit};
        if (primCnt != '1) primCnt <= primCnt + 1'b1;
      end
      if (strb.ldMLo) stageWord[M_LSB +: PAR_W] <= parBus;
      if (strb.ldMHi) begin
        stageWord[PRE_POS]         <= parBus[PAR_W-1];
        stageWord[M_LSB + M_W - 1] <= parBus[PAR_W-2];
        stageWord[R_LSB +: R_W]    <= parBus[R_W-1:0];
      end
      if (strb.ldA) stageWord[A_LSB +: A_W] <= parBus[A_W-1:0];
      if (strb.commitPrim) primCnt <= '0;
    end
  end

  // active word and length flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actWord <= '0;
      lenErr  <= 1'b0;
    end else begin
      if (strb.commitPrim) begin
        actWord <= stageWord;
        lenErr  <= strb.serialMode && (primCnt != PRIM_CNT);
      end
      if (strb.captureEnh) lenErr <= (enhCnt != ENH_CNT);
    end
  end

  // enhancement shift register and holding buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enhShift <= '0;
      enhBuf   <= '0;
      enhCnt   <= '0;
    end else begin
      if (strb.shiftEnh) begin
        enhShift <= {enhShift[ENH_W-2:0], strb.sdataBit};
        if (enhCnt != '1) enhCnt <= enhCnt + 1'b1;
      end
      if (strb.captureEnh) begin
        enhBuf <= enhShift;
        enhCnt <= '0;
      end
    end
  end

  always_comb begin
    if (strb.directMode) begin
      mVal  = {{(M_W - M_KEEP){1'b0}}, pinM};
      rVal  = {{(R_W - R_KEEP){1'b0}}, pinR};
      aVal  = pinA;
      preEn = pinPre;
    end else begin
      mVal  = actWord[M_LSB +: M_W];
      rVal  = actWord[R_LSB +: R_W];
      aVal  = actWord[A_LSB +: A_W];
      preEn = actWord[PRE_POS];
    end
    enhCtl = enhEnN ? '0 : enhBuf;
  end

  // R4: active word only moves on a transfer strobe
  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitPrim |=> $stable(actWord));

  // R5: enhancement buffer only moves on its commit edge
  p_enh_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureEnh |=> $stable(enhBuf));

  // R10: full-length serial transfer leaves the flag clear
  p_len_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitPrim && strb.serialMode && !strb.captureEnh && primCnt == PRIM_CNT)
    |=> !lenErr);

  // R10: wrong-length serial transfer raises the flag
  p_len_bad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitPrim && strb.serialMode && !strb.captureEnh && primCnt != PRIM_CNT)
    |=> lenErr);
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
  import synth_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdataIn,
  input  logic              sclkIn,
  input  logic              primWrIn,
  input  logic              enhWrIn,
  input  logic              enhEnN,
  input  logic              directSelIn,
  input  logic              serialSelIn,
  input  logic [PAR_W-1:0]  parBus,
  input  logic              mLoWrIn,
  input  logic              mHiWrIn,
  input  logic              aWrIn,
  input  logic [M_KEEP-1:0] pinM,
  input  logic [R_KEEP-1:0] pinR,
  input  logic [A_W-1:0]    pinA,
  input  logic              pinPre,
  output logic [M_W-1:0]    mVal,
  output logic [R_W-1:0]    rVal,
  output logic [A_W-1:0]    aVal,
  output logic              preEn,
  output logic [ENH_W-1:0]  enhCtl,
  output logic              lenErr
);
  ldStrobe_t strb;

  synth_ld_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sdataIn     (sdataIn),
    .sclkIn      (sclkIn),
    .primWrIn    (primWrIn),
    .enhWrIn     (enhWrIn),
    .mLoWrIn     (mLoWrIn),
    .mHiWrIn     (mHiWrIn),
    .aWrIn       (aWrIn),
    .directSelIn (directSelIn),
    .serialSelIn (serialSelIn),
    .strb        (strb)
  );

  synth_ld_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .parBus (parBus),
    .enhEnN (enhEnN),
    .pinM   (pinM),
    .pinR   (pinR),
    .pinA   (pinA),
    .pinPre (pinPre),
    .mVal   (mVal),
    .rVal   (rVal),
    .aVal   (aVal),
    .preEn  (preEn),
    .enhCtl (enhCtl),
    .lenErr (lenErr)
  );

  // R8: in direct mode the upper counter bits are held at zero
  p_direct_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.directMode |-> (mVal[M_W-1:M_KEEP] == '0 && rVal[R_W-1:R_KEEP] == '0));
endmodule

// File: tb/tb_synth_word_loader.sv
`timescale 1ns/1ps
module tb_synth_word_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdataIn = 0, sclkIn = 0, primWrIn = 0, enhWrIn = 0, enhEnN = 0;
  logic directSelIn = 0, serialSelIn = 0, mLoWrIn = 0, mHiWrIn = 0, aWrIn = 0;
  logic [7:0] parBus = '0;
  logic [6:0] pinM = '0;
  logic [3:0] pinR = '0, pinA = '0;
  logic pinPre = 0;
  logic [8:0] mVal;
  logic [5:0] rVal;
  logic [3:0] aVal;
  logic preEn;
  logic [7:0] enhCtl;
  logic lenErr;

  synth_word_loader dut (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0;
  // model: 0 parallel, 1 serial, 2 direct
  int mode = 0;
  logic [19:0] mStage = '0, mAct = '0;
  logic [7:0] mEnhSh = '0, mEnhBuf = '0;
  logic mLen = 0;
  int pCnt = 0, eCnt = 0;

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic checkOuts(string req);
    int em, er, ea, ep;
    if (mode == 2) begin
      em = int'(pinM); er = int'(pinR); ea = int'(pinA); ep = int'(pinPre);
    end else begin
      em = int'(mAct[19:11]); er = int'(mAct[10:5]);
      ea = int'(mAct[4:1]); ep = int'(mAct[0]);
    end
    chk(req, "mVal", int'(mVal), em);
    chk(req, "rVal", int'(rVal), er);
    chk(req, "aVal", int'(aVal), ea);
    chk(req, "preEn", int'(preEn), ep);
    chk(req, "enhCtl", int'(enhCtl), enhEnN ? 0 : int'(mEnhBuf));
    chk(req, "lenErr", int'(lenErr), int'(mLen));
  endtask

  task automatic setMode(int m, logic serAlt);
    mode = m;
    directSelIn = (m == 2);
    serialSelIn = (m == 2) ? serAlt : (m == 1);
    step();
  endtask

  task automatic sBit(logic b);
    sdataIn = b; sclkIn = 1'b1; step();
    sclkIn = 1'b0; step();
    if (mode == 1) begin
      if (enhWrIn) begin
        mEnhSh = {mEnhSh[6:0], b};
        if (eCnt < 31) eCnt++;
      end else begin
        mStage = {mStage[18:0], b};
        if (pCnt < 31) pCnt++;
      end
    end
  endtask

  task automatic commit();
    primWrIn = 1'b1; step();
    primWrIn = 1'b0; step();
    if (mode != 2) begin
      mAct = mStage;
      mLen = (mode == 1) ? (pCnt != 20) : 1'b0;
      pCnt = 0;
    end
  endtask

  task automatic sendPrim(int len, logic [31:0] bits);
    for (int i = len - 1; i >= 0; i--) sBit(bits[i]);
  endtask

  task automatic sendEnh(int len, logic [7:0] bits);
    enhWrIn = 1'b1; step();
    for (int i = len - 1; i >= 0; i--) sBit(bits[i]);
    enhWrIn = 1'b0; step();
    if (mode == 1) begin
      mEnhBuf = mEnhSh;
      mLen = (eCnt != 8);
      eCnt = 0;
    end
  endtask

  task automatic parWr(int which, logic [7:0] b);
    parBus = b;
    case (which)
      0: mLoWrIn = 1'b1;
      1: mHiWrIn = 1'b1;
      default: aWrIn = 1'b1;
    endcase
    step();
    mLoWrIn = 0; mHiWrIn = 0; aWrIn = 0;
    step();
    if (mode == 0) begin
      case (which)
        0: mStage[18:11] = b;
        1: begin mStage[0] = b[7]; mStage[19] = b[6]; mStage[10:5] = b[5:0]; end
        default: mStage[4:1] = b[3:0];
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    checkOuts("R1");

    // R3 / R4: exact 20-bit serial word, invisible until transfer
    setMode(1, 0);
    sendPrim(20, 32'hA5C3B);
    checkOuts("R4");
    commit();
    checkOuts("R3");
    chk("R3", "mVal field", int'(mVal), 9'h14B);

    // R5 / R6: enhancement word and its gate
    enhEnN = 1'b1;
    sendEnh(8, 8'h9D);
    checkOuts("R6");
    enhEnN = 1'b0; step();
    checkOuts("R5");
    chk("R6", "enhCtl open", int'(enhCtl), 8'h9D);

    // R10: short word raises the flag
    sendPrim(17, 32'h1ABCD);
    commit();
    checkOuts("R10");
    chk("R10", "short flag", int'(lenErr), 1);

    // R11: long word keeps its last 20 bits
    sendPrim(23, 32'h5F0F0F);
    commit();
    checkOuts("R11");
    chk("R11", "aVal tail", int'(aVal), 4'h7);

    // R10: short enhancement word
    sendEnh(6, 8'h2A);
    checkOuts("R10");

    // R7 / R9: parallel writes, serial clocks ignored
    setMode(0, 0);
    parWr(0, 8'h3C);
    parWr(1, 8'hC5);
    parWr(2, 8'hF9);
    sendPrim(5, 32'h1F);
    commit();
    checkOuts("R7");
    chk("R9", "parallel flag", int'(lenErr), 0);

    // R5 / R9: enhancement fall outside serial mode ignored
    sendEnh(8, 8'h11);
    checkOuts("R9");

    // R9: byte strobes in serial mode ignored
    setMode(1, 0);
    parWr(0, 8'hFF);
    sendPrim(20, 32'h00000);
    commit();
    checkOuts("R9");

    // R8 / R2: direct mode, serialSelIn ignored, transfers ignored
    pinM = 7'h55; pinR = 4'hA; pinA = 4'h3; pinPre = 1;
    setMode(2, 1);
    checkOuts("R8");
    serialSelIn = 0; step();
    checkOuts("R2");
    commit();
    setMode(1, 0);
    checkOuts("R8");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: begin
          int ln;
          setMode(1, 0);
          case ($urandom % 4) 0: ln = 17; 1: ln = 23; default: ln = 20; endcase
          sendPrim(ln, $urandom);
          commit();
          checkOuts("R3");
        end
        1: begin
          setMode(1, 0);
          sendEnh(($urandom % 3 == 0) ? 7 : 8, 8'($urandom));
          checkOuts("R5");
        end
        2: begin
          setMode(0, 0);
          for (int k = 0; k < 3; k++)
            if ($urandom % 2 == 1) parWr(k, 8'($urandom));
          checkOuts("R4");
          commit();
          checkOuts("R7");
        end
        3: begin
          pinM = 7'($urandom); pinR = 4'($urandom);
          pinA = 4'($urandom); pinPre = 1'($urandom);
          setMode(2, 1'($urandom));
          checkOuts("R8");
        end
        4: begin
          enhEnN = ~enhEnN; step();
          checkOuts("R6");
        end
        default: begin
          setMode(1, 0);
          sendPrim(9, $urandom);
          checkOuts("R4");
        end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule